// File: doc/BRIEF.md
# Four-Channel Load-Strobed Clock Divider Bank

This block derives four divided clocks from one fast source clock. Software programs it through a small 32-bit register write port that holds two control words. A divisor field written into the first word does nothing until software pulses that channel's own load bit. A rising edge on a load bit copies the field into the channel, and the channel switches to the new ratio at the start of its next output period, so no short pulse reaches the output.

The second word holds an active-low enable that must be high before any load is accepted. It also returns a sticky error flag for each channel. Channel 0 treats its field as a coded index into a fixed, non-monotonic ratio list. Channels 1 to 3 use the field value directly as the ratio. A ratio of 1 passes the source clock straight through. For odd ratios the high phase is one source cycle longer than the low phase.

The source clock also clocks the register port, so a load bit edge is detected in the same clock domain as the counters.

Top module: `clkdiv_bank`

## Requirements
- R1: Control word 0 is at byte offset 0 and control word 1 is at offset 4. Both read back the value last written. Other offsets read 0 and ignore writes. After reset, word 0 reads 0x00408104 and word 1 reads 0.
- R2: Channel c (0 to 3) takes its 6-bit field from word 0 bits [1+7c+5 : 1+7c] and its load bit from bit 7+7c. Loading one channel leaves the ratios of the other channels unchanged.
- R3: A channel latches its field only on a 0-to-1 transition of its load bit. Changing the field while the load bit does not rise has no effect on the output.
- R4: While word 1 bit 10 is 0, load-bit edges are ignored and every ratio is kept.
- R5: The channel 0 field is an index. Indices 1 to 10 select ratios 2, 1, 3, 4, 6, 5, 7, 8, 10, 9 in that order.
- R6: On channels 1 to 3 the field value 1 to 63 is the ratio.
- R7: Loading channel 0 with index 0 or an index of 11 or more, or loading a channel 1 to 3 with 0, keeps the previous ratio. It also sets a sticky error flag in word 1 bit 16+c. The flag reads 1 whatever is later written and is cleared only by reset.
- R8: A loaded ratio N takes effect at the next start of that channel's output period. Each period is high for ceil(N/2) source cycles, then low for floor(N/2) source cycles.
- R9: At ratio 1 the output equals the source clock.
- R10: After reset every channel runs at ratio 1, which is index 2 on channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock; also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Byte offset of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Byte offset of the read |
| rdData | output | 32 | Read data, combinational from rdAddr |
| divClk | output | 4 | Divided clocks, bit c is channel c |

## Verification
The assertions rely on a few properties of the inputs. The register port is driven by synchronous, full-word writes. Reads never target the offset being written in the same cycle unless that offset is the one checked. A load pulse is held long enough for the one-cycle edge detector to see both of its edges. The stimulus meets these conditions by changing all inputs half a cycle away from the clock edge. It issues each divisor update as the three-write sequence: field first, then load set, then load cleared after at least 15 source cycles. It waits more than two maximum-length periods before measuring an output, so every pending ratio has been applied.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int NUM_CH       = 4;
  localparam int FIELD_W      = 6;
  localparam int FIELD_BASE   = 1;
  localparam int FIELD_STRIDE = FIELD_W + 1;
  localparam int DATA_W       = 32;
  localparam int NRST_BIT     = 10;
  localparam int ERR_BASE     = 16;
  localparam int CODED_CH     = 0;
  localparam int CODED_RESET  = 2;

  typedef logic [FIELD_W-1:0] ratio_t;

  typedef struct packed {
    logic   [NUM_CH-1:0] load;
    ratio_t [NUM_CH-1:0] ratio;
  } divStb_t;

  // index -> ratio for the coded channel; 0 means illegal
  function automatic ratio_t codedRatio(input ratio_t idx);
    case (idx)
      6'd1:    return 6'd2;
      6'd2:    return 6'd1;
      6'd3:    return 6'd3;
      6'd4:    return 6'd4;
      6'd5:    return 6'd6;
      6'd6:    return 6'd5;
      6'd7:    return 6'd7;
      6'd8:    return 6'd8;
      6'd9:    return 6'd10;
      6'd10:   return 6'd9;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] resetWord0();
    logic [DATA_W-1:0] w;
    w = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      w[FIELD_BASE + c*FIELD_STRIDE +: FIELD_W] =
        (c == CODED_CH) ? ratio_t'(CODED_RESET) : ratio_t'(1);
    end
    return w;
  endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output divStb_t           stb,
  output logic              dividerRun
);
  localparam logic [ADDR_W-1:0] OFS_W0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_W1 = ADDR_W'(4);

  logic [DATA_W-1:0] word0, word1;
  logic [NUM_CH-1:0] loadNow, loadPrev, loadEdge, legal, errSticky;
  ratio_t            decRatio [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word0 <= resetWord0();
      word1 <= '0;
    end else if (wrEn) begin
      if (wrAddr == OFS_W0) word0 <= wrData;
      if (wrAddr == OFS_W1) word1 <= wrData;
    end
  end

  assign dividerRun = word1[NRST_BIT];

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ratio_t field;
      field       = word0[FIELD_BASE + c*FIELD_STRIDE +: FIELD_W];
      loadNow[c]  = word0[FIELD_BASE + c*FIELD_STRIDE + FIELD_W];
      decRatio[c] = (c == CODED_CH) ? codedRatio(field) : field;
      legal[c]    = (decRatio[c] != '0);
    end
    loadEdge = loadNow & ~loadPrev & {NUM_CH{dividerRun}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadPrev  <= '0;
      errSticky <= '0;
      stb       <= '0;
    end else begin
      loadPrev  <= loadNow;
      errSticky <= errSticky | (loadEdge & ~legal);
      stb.load  <= loadEdge & legal;
      for (int c = 0; c < NUM_CH; c++) stb.ratio[c] <= decRatio[c];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == OFS_W0) rdData = word0;
    if (rdAddr == OFS_W1) begin
      rdData = word1;
      rdData[ERR_BASE +: NUM_CH] = word1[ERR_BASE +: NUM_CH] | errSticky;
    end
  end
endmodule

// File: rtl/clkdiv_dp.sv
`timescale 1ns/1ps
module clkdiv_dp
  import clkdiv_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  divStb_t                   stb,
  output logic [NUM_CH-1:0]         divClk,
  output logic [NUM_CH*FIELD_W-1:0] curFlat,
  output logic [NUM_CH-1:0]         qFlat
);
  localparam int WIDE_W = FIELD_W + 1;

  ratio_t            cur  [NUM_CH];
  ratio_t            pend [NUM_CH];
  ratio_t            cnt  [NUM_CH];
  logic [NUM_CH-1:0] pendV, q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        cur[c]  <= ratio_t'(1);
        pend[c] <= ratio_t'(1);
        cnt[c]  <= '0;
      end
      pendV <= '0;
      q     <= '1;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        logic [WIDE_W-1:0] hiLen, nxt;
        hiLen = ({1'b0, cur[c]} + WIDE_W'(1)) >> 1;
        nxt   = {1'b0, cnt[c]} + WIDE_W'(1);
        if (cnt[c] == cur[c] - ratio_t'(1)) begin
          // period boundary: output rises, pending ratio applies
          cnt[c] <= '0;
          q[c]   <= 1'b1;
          if (pendV[c]) begin
            cur[c]   <= pend[c];
            pendV[c] <= 1'b0;
          end
        end else begin
          cnt[c] <= nxt[FIELD_W-1:0];
          q[c]   <= (nxt < hiLen);
        end
        if (stb.load[c]) begin
          pend[c]  <= stb.ratio[c];
          pendV[c] <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    assign divClk[g] = (cur[g] == ratio_t'(1)) ? clk : q[g];
    assign curFlat[g*FIELD_W +: FIELD_W] = cur[g];
  end
  assign qFlat = q;
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] divClk
);
  divStb_t                   stb;
  logic                      dividerRun;
  logic [NUM_CH*FIELD_W-1:0] curFlat;
  logic [NUM_CH-1:0]         qFlat;

  clkdiv_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .stb(stb), .dividerRun(dividerRun)
  );

  clkdiv_dp i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .divClk(divClk), .curFlat(curFlat), .qFlat(qFlat)
  );
endmodule

// File: rtl/clkdiv_bank_chk.sv
`timescale 1ns/1ps
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wrEn,
  input logic [ADDR_W-1:0]         wrAddr,
  input logic [DATA_W-1:0]         wrData,
  input logic [ADDR_W-1:0]         rdAddr,
  input logic [DATA_W-1:0]         rdData,
  input logic [NUM_CH-1:0]         loadStb,
  input logic                      divEnable,
  input logic [NUM_CH*FIELD_W-1:0] curFlat,
  input logic [NUM_CH-1:0]         qFlat
);
  // R1: a write to word 0 is visible on the next read of word 0
  p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == ADDR_W'(0)) |=>
      (rdAddr != ADDR_W'(0) || rdData == $past(wrData)));

  // R7: error flags never clear while word 1 stays selected
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddr == ADDR_W'(4)) |=>
      (rdAddr != ADDR_W'(4) ||
       (rdData[ERR_BASE +: NUM_CH] & $past(rdData[ERR_BASE +: NUM_CH]))
         == $past(rdData[ERR_BASE +: NUM_CH])));

  // R4: no latch strobe unless the enable was high when the edge was seen
  p_load_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|loadStb) |-> $past(divEnable));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    // R8: a ratio switch coincides with the output starting its high phase
    p_switch_at_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(curFlat[g*FIELD_W +: FIELD_W]) |-> qFlat[g]);
    // R7: an illegal ratio never becomes active
    p_ratio_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      curFlat[g*FIELD_W +: FIELD_W] != '0);
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .loadStb(stb.load),
  .divEnable(dividerRun), .curFlat(curFlat), .qFlat(qFlat)
);

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
module test_clkdiv_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [3:0]  divClk;

  int nRun = 0, nFail = 0;
  logic [31:0] w0 = 32'h00408104;
  logic [31:0] w1 = 32'h0;

  always #10 clk = ~clk;

  clkdiv_bank i_clkdiv_bank (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .divClk(divClk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic update(input int ch, input int val);
    int lsb = 1 + 7*ch;
    w0[lsb +: 6] = val[5:0];
    w0[lsb + 6] = 1'b0;
    wr(3'd0, w0);
    w0[lsb + 6] = 1'b1;
    wr(3'd0, w0);
    repeat (15) @(posedge clk);
    w0[lsb + 6] = 1'b0;
    wr(3'd0, w0);
    repeat (140) @(posedge clk);
  endtask

  task automatic measure(input int ch, output int ratio, output int hi);
    logic s [0:139];
    int i0 = -1, i1 = -1, ones = 0;
    for (int i = 0; i < 140; i++) begin
      @(posedge clk); #5;
      s[i] = divClk[ch];
      if (s[i]) ones++;
    end
    for (int i = 1; i < 140; i++) begin
      if (s[i] && !s[i-1]) begin
        if (i0 < 0) i0 = i;
        else if (i1 < 0) i1 = i;
      end
    end
    hi = 0;
    if (i1 > 0) begin
      ratio = i1 - i0;
      for (int i = i0; i < i1; i++) if (s[i]) hi++;
    end else if (ones == 140) begin
      ratio = 1; hi = 1;
    end else ratio = 0;
  endtask

  task automatic expectRatio(input int ch, input int expR, input string req);
    int r, h;
    measure(ch, r, h);
    check(r == expR, req, r, expR);
    if (expR > 1) check(h == (expR + 1) / 2, "R8 high phase", h, (expR + 1) / 2);
    else begin
      @(negedge clk); #1;
      check(divClk[ch] == 1'b0, "R9 follows source low phase", divClk[ch], 0);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check(d == 32'h00408104, "R1 reset word0", d, 32'h00408104);
    rd(3'd4, d); check(d == 32'h0, "R1 reset word1", d, 0);
    for (int c = 0; c < 4; c++) expectRatio(c, 1, "R10 reset ratio");
  endtask

  task automatic t_holdoff();
    update(1, 5);
    expectRatio(1, 1, "R4 load ignored while disabled");
    w1[10] = 1'b1;
    wr(3'd4, w1);
  endtask

  task automatic t_direct();
    update(1, 5);  expectRatio(1, 5, "R6 ch1 ratio 5");
    update(2, 2);  expectRatio(2, 2, "R6 ch2 ratio 2");
    expectRatio(1, 5, "R2 ch1 untouched by ch2 load");
    update(3, 63); expectRatio(3, 63, "R6 ch3 ratio 63");
    update(1, 1);  expectRatio(1, 1, "R9 ch1 back to ratio 1");
  endtask

  task automatic t_coded();
    update(0, 1);  expectRatio(0, 2, "R5 index 1");
    update(0, 6);  expectRatio(0, 5, "R5 index 6");
    update(0, 10); expectRatio(0, 9, "R5 index 10");
    update(0, 9);  expectRatio(0, 10, "R5 index 9");
  endtask

  task automatic t_noLoad();
    w0[22 +: 6] = 6'd7;
    wr(3'd0, w0);
    repeat (200) @(posedge clk);
    expectRatio(3, 63, "R3 field change without load edge");
  endtask

  task automatic t_invalid();
    logic [31:0] d;
    update(0, 11); expectRatio(0, 10, "R7 ch0 index 11 keeps ratio");
    rd(3'd4, d);   check(d[16] == 1'b1, "R7 ch0 error flag", d[16], 1);
    update(2, 0);  expectRatio(2, 2, "R7 ch2 zero keeps ratio");
    rd(3'd4, d);   check(d[19:16] == 4'b0101, "R7 error flags", d[19:16], 5);
    wr(3'd4, 32'h0000_0400);
    rd(3'd4, d);   check(d == 32'h0005_0400, "R7 flags survive write", d, 32'h0005_0400);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    rd(3'd0, d); check(d == w0, "R1 word0 readback", d, w0);
    wr(3'd4, 32'h5A20_0401);
    rd(3'd4, d); check(d == 32'h5A25_0401, "R1 word1 readback", d, 32'h5A25_0401);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); check(d == 32'h0, "R1 unmapped offset", d, 0);
    rd(3'd0, d); check(d == w0, "R1 unmapped write ignored", d, w0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_holdoff();
    t_direct();
    t_coded();
    t_noLoad();
    t_invalid();
    t_readback();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule